// File: doc/BRIEF.md
# Coded Trigger and Reset Command Decoder

This block watches a single coded command line that is sampled once per clock. A command is a three-sample frame: a start sample that is always 1, then two code samples. The decoder turns each complete frame into a one-cycle strobe on one of four outputs: trigger, event-count clear, bunch-count clear or global reset. Trigger strobes advance an event counter. Event-count clear and global reset zero that counter. Bunch-count clear is decoded and reported, but it changes nothing inside the block.

The block also drives a copy of the command line to front-end devices after a fixed four-cycle delay. Software-style test commands can be requested through a four-bit request input. Each request is serialised into the same three-sample framing and slipped onto the line when no external frame is in progress. It is then decoded and forwarded exactly like an external command. Every request also sets a sticky "generated" flag that stays set until a clear input removes it.

Top module: `cmd_line_decoder`

## Requirements
- R1: While idle the decoder ignores 0 samples. A 1 sample opens a frame. The two following samples are its code bits. Exactly one strobe is high during the cycle after the clock edge that samples the second code bit.
- R2: The code bits, first then second, select the command: 0,0 trigger; 0,1 event-count clear; 1,0 bunch-count clear; 1,1 global reset.
- R3: Frames may follow each other with no gap, one every three clocks, and each is decoded. At most one strobe is high at a time, and after any strobe the next two cycles carry no strobe.
- R4: A trigger strobe raises the event counter by one on the following clock edge, wrapping from its maximum value to zero. Without a strobe the counter holds its value.
- R5: An event-count-clear strobe or a global-reset strobe sets the event counter to zero on the following clock edge.
- R6: A bunch-count-clear strobe leaves the event counter unchanged.
- R7: The forwarded line equals the merged command line (the external line, with local test frames inserted) four clock cycles later. With no test activity it is the external line delayed by four cycles.
- R8: Test request bit 0 asks for a trigger, bit 1 for an event-count clear, bit 2 for a bunch-count clear and bit 3 for a global reset. Each requested command is framed, decoded and forwarded like an external one. With an idle line, the strobe appears four cycles after the request cycle.
- R9: A pending test frame starts only in a cycle where the decoder is idle and the external line is 0. An external frame in progress is completed first, and the test frame starts in the first cycle after it.
- R10: While the two code samples of a test frame are being inserted, the external line is ignored by both the decoder and the forwarded line.
- R11: A test request sets the matching sticky generated flag on the next edge. A clear bit resets its flag. A set and a clear of the same bit in one cycle leave the flag set.
- R12: Several pending test commands are sent one after another, lowest request bit first, with no idle cycle between their frames.
- R13: After reset all strobes, the forwarded line, the event counter and the generated flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_i | input | 1 | External coded command line |
| test_set_i | input | 4 | Test command requests (bit 0 trigger, 1 event clear, 2 bunch clear, 3 global reset) |
| test_clr_i | input | 4 | Clears of the sticky generated flags, same bit order |
| fwd_line_o | output | 1 | Merged command line delayed by four cycles |
| trig_o | output | 1 | Trigger strobe |
| ecr_o | output | 1 | Event-count-clear strobe |
| bcr_o | output | 1 | Bunch-count-clear strobe |
| gres_o | output | 1 | Global-reset strobe |
| evt_cnt_o | output | EVT_W | Event counter |
| test_gen_o | output | 4 | Sticky generated flags |

## Verification
Every one of the four code values is sent alone, so a swapped code bit or a wrong strobe mapping shows up directly. Gapless frames check that the framer returns to idle in time to take the next start sample. Long runs of zeros check that idle is stable. A pseudo-random bit stream is compared sample by sample against the forwarded line, which checks the four-cycle delay independently of framing. Test requests are tried on an idle line, during an external frame, with the external line held high across the inserted code slots, and several at once. These cases separate the launch condition, the merge priority and the service order.

// File: rtl/cmdec_pkg.sv
package cmdec_pkg;
  localparam int NCMD = 4;
  localparam int SELW = $clog2(NCMD);

  typedef enum logic [SELW-1:0] {
    CMD_TRIG = 2'b00,
    CMD_ECR  = 2'b01,
    CMD_BCR  = 2'b10,
    CMD_GRES = 2'b11
  } cmd_e;

  typedef enum logic [1:0] {
    FR_IDLE  = 2'b00,
    FR_START = 2'b01,
    FR_CODE1 = 2'b10
  } fr_state_e;
endpackage

// File: rtl/cmd_framer.sv
module cmd_framer
  import cmdec_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_i,
  output logic            idle_o,
  output logic [NCMD-1:0] strobe_o
);
  fr_state_e       state_q, state_d;
  logic            code1_q, code1_d, code1_en;
  logic [NCMD-1:0] strb_q, strb_d;

  always_comb begin
    state_d  = state_q;
    code1_d  = code1_q;
    code1_en = 1'b0;
    strb_d   = '0;
    case (state_q)
      FR_IDLE: begin
        if (bit_i) state_d = FR_START;
      end
      FR_START: begin
        code1_d  = bit_i;
        code1_en = 1'b1;
        state_d  = FR_CODE1;
      end
      FR_CODE1: begin
        strb_d[{code1_q, bit_i}] = 1'b1;
        state_d                  = FR_IDLE;
      end
      default: state_d = FR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FR_IDLE;
      code1_q <= 1'b0;
      strb_q  <= '0;
    end else begin
      state_q <= state_d;
      strb_q  <= strb_d;
      if (code1_en) code1_q <= code1_d;
    end
  end

  assign idle_o   = (state_q == FR_IDLE);
  assign strobe_o = strb_q;
endmodule

// File: rtl/cmd_test_inject.sv
module cmd_test_inject
  import cmdec_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCMD-1:0] set_i,
  input  logic [NCMD-1:0] clr_i,
  input  logic            line_i,
  input  logic            framer_idle_i,
  output logic            merged_o,
  output logic [NCMD-1:0] gen_o
);
  logic [NCMD-1:0] pend_q, pend_d;
  logic [NCMD-1:0] gen_q, gen_d;
  logic [1:0]      slot_q, slot_d;
  logic [SELW-1:0] code_q, code_d;
  logic [SELW-1:0] pick;
  logic [NCMD-1:0] pick_mask;
  logic            launch;

  function automatic logic [SELW-1:0] lowest_set(input logic [NCMD-1:0] v);
    logic [SELW-1:0] r;
    r = '0;
    for (int i = NCMD - 1; i >= 0; i--) begin
      if (v[i]) r = SELW'(i);
    end
    return r;
  endfunction

  always_comb begin
    pick      = lowest_set(pend_q);
    pick_mask = '0;
    pick_mask[pick] = 1'b1;
    launch    = framer_idle_i && !line_i && (slot_q == 2'd0) && (|pend_q);

    pend_d = (pend_q & ~(launch ? pick_mask : '0)) | set_i;
    gen_d  = (gen_q & ~clr_i) | set_i;

    code_d = code_q;
    slot_d = 2'd0;
    if (launch) begin
      code_d = pick;
      slot_d = 2'd1;
    end else if (slot_q == 2'd1) begin
      slot_d = 2'd2;
    end

    if (slot_q == 2'd1)      merged_o = code_q[1];
    else if (slot_q == 2'd2) merged_o = code_q[0];
    else if (launch)         merged_o = 1'b1;
    else                     merged_o = line_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      gen_q  <= '0;
      slot_q <= 2'd0;
      code_q <= '0;
    end else begin
      pend_q <= pend_d;
      gen_q  <= gen_d;
      slot_q <= slot_d;
      if (launch) code_q <= code_d;
    end
  end

  assign gen_o = gen_q;
endmodule

// File: rtl/cmd_delay_line.sv
module cmd_delay_line #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [DEPTH-1:0] stage_q;

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
      logic src;
      if (g == 0) begin : g_first
        assign src = d_i;
      end else begin : g_next
        assign src = stage_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= 1'b0;
        else        stage_q[g] <= src;
      end
    end
  endgenerate

  assign q_o = stage_q[DEPTH-1];
endmodule

// File: rtl/cmd_evt_counter.sv
module cmd_evt_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         clear_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = inc_i | clear_i;
    if (clear_i) cnt_d = '0;
    else         cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/cmd_line_decoder.sv
module cmd_line_decoder
  import cmdec_pkg::*;
#(
  parameter int EVT_W     = 8,
  parameter int FWD_DELAY = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_i,
  input  logic [NCMD-1:0]  test_set_i,
  input  logic [NCMD-1:0]  test_clr_i,
  output logic             fwd_line_o,
  output logic             trig_o,
  output logic             ecr_o,
  output logic             bcr_o,
  output logic             gres_o,
  output logic [EVT_W-1:0] evt_cnt_o,
  output logic [NCMD-1:0]  test_gen_o
);
  logic [1:0]      rst_pipe_q;
  logic            rst_sync_n;
  logic            merged_line;
  logic            framer_idle;
  logic [NCMD-1:0] strb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  cmd_test_inject u_inject (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .set_i         (test_set_i),
    .clr_i         (test_clr_i),
    .line_i        (line_i),
    .framer_idle_i (framer_idle),
    .merged_o      (merged_line),
    .gen_o         (test_gen_o)
  );

  cmd_framer u_framer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .bit_i    (merged_line),
    .idle_o   (framer_idle),
    .strobe_o (strb)
  );

  cmd_delay_line #(.DEPTH(FWD_DELAY)) u_fwd (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   (merged_line),
    .q_o   (fwd_line_o)
  );

  cmd_evt_counter #(.W(EVT_W)) u_evt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .inc_i   (strb[CMD_TRIG]),
    .clear_i (strb[CMD_ECR] | strb[CMD_GRES]),
    .cnt_o   (evt_cnt_o)
  );

  assign trig_o = strb[CMD_TRIG];
  assign ecr_o  = strb[CMD_ECR];
  assign bcr_o  = strb[CMD_BCR];
  assign gres_o = strb[CMD_GRES];
endmodule

// File: rtl/cmd_line_decoder_chk.sv
module cmd_line_decoder_chk #(
  parameter int EVT_W     = 8,
  parameter int FWD_DELAY = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       set_i,
  input logic             trig_i,
  input logic             ecr_i,
  input logic             bcr_i,
  input logic             gres_i,
  input logic [EVT_W-1:0] cnt_i,
  input logic             fwd_i,
  input logic             merged_i,
  input logic [3:0]       gen_i
);
  logic [2:0] since_q;
  logic [3:0] strb;
  logic       any_s;

  assign strb  = {gres_i, bcr_i, ecr_i, trig_i};
  assign any_s = |strb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               since_q <= 3'd0;
    else if (since_q != 3'd7) since_q <= since_q + 3'd1;
  end

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strb)); // R3

  AST_STROBE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (since_q >= 3'd2 && ($past(any_s, 1) || $past(any_s, 2))) |-> !any_s); // R3

  AST_CNT_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (since_q >= 3'd1 && $past(trig_i)) |-> cnt_i == EVT_W'($past(cnt_i) + 1'b1)); // R4

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (since_q >= 3'd1 && !$past(any_s)) |-> $stable(cnt_i)); // R4

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (since_q >= 3'd1 && ($past(ecr_i) || $past(gres_i))) |-> cnt_i == '0); // R5

  AST_BCR_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (since_q >= 3'd1 && $past(bcr_i)) |-> $stable(cnt_i)); // R6

  AST_GEN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (since_q >= 3'd1) |-> (($past(set_i) & ~gen_i) == 4'b0000)); // R11

  generate
    if (FWD_DELAY == 4) begin : g_fwd_chk
      AST_FWD_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q >= 3'd4) |-> fwd_i == $past(merged_i, 4)); // R7
    end
  endgenerate
endmodule

bind cmd_line_decoder cmd_line_decoder_chk #(
  .EVT_W     (EVT_W),
  .FWD_DELAY (FWD_DELAY)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .set_i    (test_set_i),
  .trig_i   (trig_o),
  .ecr_i    (ecr_o),
  .bcr_i    (bcr_o),
  .gres_i   (gres_o),
  .cnt_i    (evt_cnt_o),
  .fwd_i    (fwd_line_o),
  .merged_i (merged_line),
  .gen_i    (test_gen_o)
);

// File: tb/tb_cmd_line_decoder.sv
module tb_cmd_line_decoder;
  localparam int EVT_W = 8;

  logic             clk;
  logic             rst_n;
  logic             line_i;
  logic [3:0]       test_set_i;
  logic [3:0]       test_clr_i;
  logic             fwd_line_o;
  logic             trig_o, ecr_o, bcr_o, gres_o;
  logic [EVT_W-1:0] evt_cnt_o;
  logic [3:0]       test_gen_o;
  logic [3:0]       strb;

  int n_tests = 0;
  int n_fail  = 0;

  assign strb = {gres_o, bcr_o, ecr_o, trig_o};

  cmd_line_decoder #(.EVT_W(EVT_W), .FWD_DELAY(4)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_i     (line_i),
    .test_set_i (test_set_i),
    .test_clr_i (test_clr_i),
    .fwd_line_o (fwd_line_o),
    .trig_o     (trig_o),
    .ecr_o      (ecr_o),
    .bcr_o      (bcr_o),
    .gres_o     (gres_o),
    .evt_cnt_o  (evt_cnt_o),
    .test_gen_o (test_gen_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Drives one external frame; returns at the negedge where the strobe is visible.
  task automatic send_ext(input logic b1, input logic b2);
    line_i = 1'b1;
    tick();
    chk("R3 quiet slot 1", {28'd0, strb}, 32'd0);
    line_i = b1;
    tick();
    chk("R3 quiet slot 2", {28'd0, strb}, 32'd0);
    line_i = b2;
    tick();
    line_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R13 strobes", {28'd0, strb}, 32'd0);
    chk("R13 fwd", {31'd0, fwd_line_o}, 32'd0);
    chk("R13 counter", {24'd0, evt_cnt_o}, 32'd0);
    chk("R13 gen flags", {28'd0, test_gen_o}, 32'd0);
  endtask

  task automatic t_idle();
    for (int i = 0; i < 12; i++) begin
      tick();
      chk("R1 idle zeros", {28'd0, strb}, 32'd0);
    end
  endtask

  task automatic t_codes();
    send_ext(1'b0, 1'b0);
    chk("R2 trigger code", {28'd0, strb}, 32'h1);
    tick();
    chk("R1 single strobe", {28'd0, strb}, 32'd0);
    chk("R4 increment", {24'd0, evt_cnt_o}, 32'd1);
    send_ext(1'b0, 1'b0);
    tick();
    chk("R4 second increment", {24'd0, evt_cnt_o}, 32'd2);
    send_ext(1'b1, 1'b0);
    chk("R2 bunch clear code", {28'd0, strb}, 32'h4);
    tick();
    chk("R6 bunch clear keeps count", {24'd0, evt_cnt_o}, 32'd2);
    send_ext(1'b0, 1'b1);
    chk("R2 event clear code", {28'd0, strb}, 32'h2);
    tick();
    chk("R5 event clear zeroes count", {24'd0, evt_cnt_o}, 32'd0);
    send_ext(1'b0, 1'b0);
    tick();
    send_ext(1'b1, 1'b1);
    chk("R2 global reset code", {28'd0, strb}, 32'h8);
    tick();
    chk("R5 global reset zeroes count", {24'd0, evt_cnt_o}, 32'd0);
  endtask

  task automatic t_back_to_back();
    send_ext(1'b0, 1'b0);
    chk("R3 gapless 1", {28'd0, strb}, 32'h1);
    send_ext(1'b1, 1'b0);
    chk("R3 gapless 2", {28'd0, strb}, 32'h4);
    send_ext(1'b0, 1'b0);
    chk("R3 gapless 3", {28'd0, strb}, 32'h1);
    tick();
    chk("R3 gapless count", {24'd0, evt_cnt_o}, 32'd2);
    tick();
  endtask

  task automatic t_forward();
    logic [3:0] hist;
    logic [7:0] lfsr;
    hist = 4'b0000;
    lfsr = 8'hA5;
    for (int i = 0; i < 48; i++) begin
      chk("R7 forward delay", {31'd0, fwd_line_o}, {31'd0, hist[3]});
      lfsr   = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      hist   = {hist[2:0], lfsr[0]};
      line_i = lfsr[0];
      tick();
    end
    line_i = 1'b0;
    repeat (8) tick();
    send_ext(1'b1, 1'b1);
    tick();
  endtask

  task automatic t_wrap();
    send_ext(1'b1, 1'b1);
    for (int i = 0; i < 255; i++) send_ext(1'b0, 1'b0);
    tick();
    chk("R4 count at maximum", {24'd0, evt_cnt_o}, 32'd255);
    send_ext(1'b0, 1'b0);
    tick();
    chk("R4 wrap to zero", {24'd0, evt_cnt_o}, 32'd0);
  endtask

  // Local request on an idle line; noisy holds the external line high in the code slots.
  task automatic t_local(input int idx, input logic noisy);
    logic [3:0] exp_s;
    logic [1:0] code;
    exp_s = 4'b0001 << idx;
    code  = 2'(idx);
    test_set_i = exp_s;
    tick();
    test_set_i = 4'b0000;
    chk("R11 flag set", {28'd0, test_gen_o & exp_s}, {28'd0, exp_s});
    tick();
    line_i = noisy;
    tick();
    tick();
    line_i = 1'b0;
    if (noisy) chk("R10 line ignored in slots", {28'd0, strb}, {28'd0, exp_s});
    else       chk("R8 local command strobe", {28'd0, strb}, {28'd0, exp_s});
    tick();
    chk("R8 forwarded start", {31'd0, fwd_line_o}, 32'd1);
    tick();
    if (noisy) chk("R10 forwarded code 1", {31'd0, fwd_line_o}, {31'd0, code[1]});
    else       chk("R8 forwarded code 1", {31'd0, fwd_line_o}, {31'd0, code[1]});
    tick();
    if (noisy) chk("R10 forwarded code 2", {31'd0, fwd_line_o}, {31'd0, code[0]});
    else       chk("R8 forwarded code 2", {31'd0, fwd_line_o}, {31'd0, code[0]});
    tick();
    chk("R8 forwarded idle after", {31'd0, fwd_line_o}, 32'd0);
  endtask

  task automatic t_local_waits();
    line_i     = 1'b1;
    test_set_i = 4'b0001;
    tick();
    test_set_i = 4'b0000;
    line_i     = 1'b0;
    tick();
    line_i = 1'b1;
    tick();
    line_i = 1'b0;
    chk("R9 external frame first", {28'd0, strb}, 32'h2);
    tick();
    chk("R9 no early local", {28'd0, strb}, 32'd0);
    tick();
    chk("R9 no early local 2", {28'd0, strb}, 32'd0);
    tick();
    chk("R9 local right after external", {28'd0, strb}, 32'h1);
    tick();
    chk("R9 count after clear then trigger", {24'd0, evt_cnt_o}, 32'd1);
  endtask

  task automatic t_priority();
    test_set_i = 4'b1001;
    tick();
    test_set_i = 4'b0000;
    repeat (3) tick();
    chk("R12 lowest bit served first", {28'd0, strb}, 32'h1);
    repeat (3) tick();
    chk("R12 next frame without gap", {28'd0, strb}, 32'h8);
    tick();
    chk("R12 global reset clears count", {24'd0, evt_cnt_o}, 32'd0);
  endtask

  task automatic t_flags();
    test_clr_i = 4'b1111;
    tick();
    test_clr_i = 4'b0000;
    chk("R11 flags cleared", {28'd0, test_gen_o}, 32'd0);
    test_set_i = 4'b0100;
    test_clr_i = 4'b0100;
    tick();
    test_set_i = 4'b0000;
    test_clr_i = 4'b0000;
    chk("R11 set wins over clear", {28'd0, test_gen_o}, 32'h4);
    repeat (8) tick();
    chk("R11 flag sticky", {28'd0, test_gen_o}, 32'h4);
    test_clr_i = 4'b0100;
    tick();
    test_clr_i = 4'b0000;
    chk("R11 flag cleared", {28'd0, test_gen_o}, 32'd0);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n      = 1'b0;
    line_i     = 1'b0;
    test_set_i = 4'b0000;
    test_clr_i = 4'b0000;
    repeat (5) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    t_reset();
    t_idle();
    t_codes();
    t_back_to_back();
    t_forward();
    t_wrap();
    for (int k = 0; k < 4; k++) t_local(k, 1'b0);
    t_local(0, 1'b1);
    t_local(1, 1'b1);
    t_local_waits();
    t_priority();
    t_flags();
    finish_run();
  end
endmodule